// File: doc/BRIEF.md
# Multiply-Divide Issue Interlock

This block produces the stall request that an in-order integer pipeline uses when it sends work to a multiply/divide unit that runs on its own. Each cycle the decode stage presents at most one instruction. The block receives the instruction's class, its source and destination register numbers, and a flag from the multiplier that marks a two-pass operand size (the second operand needs more than half the datapath width). It holds a small amount of history about earlier issued operations. An instruction issues in any cycle where it is valid and `stall` is low. When `stall` is high, the pipeline keeps presenting the same instruction in the next cycle.

The block keeps three kinds of history. The first is multiplier occupancy after a two-pass multiply. The second is a set of fixed hold cycles: a multiply that writes to the register file uses them to keep its write slot. The third is a one-register dependency window, which covers consumers of a register-file multiply result and consumers of a HI/LO move result. The divider supplies a busy flag of its own. While that flag is high, every multiply/divide-class instruction is held. Plain integer work still flows during that time, because the divider keeps running whatever the integer pipeline does.

Top module: `mdu_issue_interlock`

## Requirements
- R1: After reset, with no history, `stall` is low, both for an idle slot and for a valid instruction of any class.
- R2: A single-pass HI/LO multiply or accumulate (class 1 or 2, `in_two_pass`=0) followed at once by an accumulate (class 2) or a HI/LO read (class 3) causes no stall.
- R3: A two-pass multiply of class 1, 2 or 5 holds any multiply/divide-class instruction (classes 1 to 6) in the next cycle for exactly one stall cycle. A following integer instruction (class 0) is not held by this rule.
- R4: A register-file multiply (class 5) stalls whatever instruction follows it for exactly 1 cycle when single-pass and 2 cycles when two-pass.
- R5: If the instruction directly after a class 5 multiply reads its destination in `in_src_a` or `in_src_b`, that instruction gets one stall cycle on top of R4. Later instructions get no extra stall.
- R6: An instruction that reads the destination of a HI/LO read (class 3) in the next cycle stalls for one cycle. An instruction that does not read it does not stall.
- R7: A HI/LO write (class 4) followed at once by an accumulate (class 2) causes no stall.
- R8: While `div_busy` is high, every valid instruction of classes 1 to 6 is stalled, and a class 0 instruction is not.
- R9: `stall` is never high in a cycle where `in_valid` is low.
- R10: Register 0 as a destination never creates a dependency stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 3 | Class: 0 integer, 1 HI/LO multiply, 2 accumulate, 3 HI/LO read, 4 HI/LO write, 5 register-file multiply, 6 divide, 7 treated as integer |
| in_two_pass | input | 1 | Multiplier size flag: the operand needs two passes |
| in_src_a | input | 5 | First source register number, 0 when unused |
| in_src_b | input | 5 | Second source register number, 0 when unused |
| in_dst | input | 5 | Destination register number |
| div_busy | input | 1 | Divider is active, high from the cycle after a divide issues until its result is written |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
Assertions check the following on every cycle: an idle slot never stalls, a multiply/divide-class instruction never passes while the divider is busy, the cycle after a register-file multiply is always held, the cycle after a two-pass multiply holds any unit-class request, and an accumulate straight after a single-pass multiply passes. Other behaviour can only be shown by the bench's scripted sequences, because it depends on how many cycles a particular instruction spends waiting. That includes the exact stall count for each producer–consumer pair, the extra cycle that only the immediate reader of a multiply result receives, the fact that register 0 is never a dependency, and a divide that keeps counting down while integer work passes it.

// File: rtl/mdu_il_pkg.sv
package mdu_il_pkg;

  localparam int REG_W        = 5;
  localparam int MUL_HOLD_1P  = 1;
  localparam int MUL_HOLD_2P  = 2;
  localparam int DEP_EXTRA    = 1;
  localparam int MF_DEP_STALL = 1;
  localparam int TWO_PASS_OCC = 1;
  localparam int CNT_MAX      = MUL_HOLD_2P + DEP_EXTRA;
  localparam int CNT_W        = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    OP_INT  = 3'd0,
    OP_MULT = 3'd1,
    OP_MACC = 3'd2,
    OP_MFHL = 3'd3,
    OP_MTHL = 3'd4,
    OP_MUL  = 3'd5,
    OP_DIV  = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  function automatic logic unit_class(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd6);
  endfunction

  function automatic logic uses_multiplier(input logic [2:0] op);
    return (op == OP_MULT) || (op == OP_MACC) || (op == OP_MUL);
  endfunction

endpackage

// File: rtl/mdu_il_mpy_track.sv
module mdu_il_mpy_track
  import mdu_il_pkg::*;
#(
  parameter int OCC = TWO_PASS_OCC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [2:0] op,
  input  logic       two_pass,
  input  logic       req_valid,
  output logic       mpy_stall
);

  localparam int OW = $clog2(OCC + 1);

  logic [OW-1:0] occ_q, occ_n;
  logic          occ_en;

  always_comb begin
    occ_en = 1'b0;
    occ_n  = occ_q;
    if (issue && two_pass && uses_multiplier(op)) begin
      occ_en = 1'b1;
      occ_n  = OW'(OCC);
    end else if (occ_q != '0) begin
      occ_en = 1'b1;
      occ_n  = occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_n;
  end

  assign mpy_stall = req_valid && unit_class(op) && (occ_q != '0);

  AST_TWO_PASS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && two_pass && uses_multiplier(op)) |=> (!req_valid || !unit_class(op) || mpy_stall)); // R3

endmodule

// File: rtl/mdu_il_gpr_track.sv
module mdu_il_gpr_track
  import mdu_il_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             req_valid,
  input  logic [2:0]       op,
  input  logic             two_pass,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] dst,
  output logic             gpr_stall
);

  logic [CNT_W-1:0] hold_q, hold_n;
  logic [CNT_W-1:0] dep_q, dep_n;
  logic [REG_W-1:0] dreg_q, dreg_n;
  logic             cnt_en, dreg_en;
  logic             reads_dep;

  always_comb begin
    hold_n  = (hold_q != '0) ? hold_q - 1'b1 : hold_q;
    dep_n   = (dep_q  != '0) ? dep_q  - 1'b1 : dep_q;
    dreg_n  = dreg_q;
    dreg_en = 1'b0;
    if (issue) begin
      dreg_en = 1'b1;
      dreg_n  = dst;
      if (op == OP_MUL) begin
        hold_n = two_pass ? CNT_W'(MUL_HOLD_2P) : CNT_W'(MUL_HOLD_1P);
        dep_n  = two_pass ? CNT_W'(MUL_HOLD_2P + DEP_EXTRA)
                          : CNT_W'(MUL_HOLD_1P + DEP_EXTRA);
      end else if (op == OP_MFHL) begin
        hold_n = '0;
        dep_n  = CNT_W'(MF_DEP_STALL);
      end else begin
        dep_n  = '0;
      end
    end
    cnt_en = issue || (hold_q != '0) || (dep_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dep_q  <= '0;
    end else if (cnt_en) begin
      hold_q <= hold_n;
      dep_q  <= dep_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dreg_q <= '0;
    else if (dreg_en) dreg_q <= dreg_n;
  end

  assign reads_dep = (dreg_q != '0) && ((src_a == dreg_q) || (src_b == dreg_q));
  assign gpr_stall = req_valid && ((hold_q != '0) || ((dep_q != '0) && reads_dep));

  AST_MUL_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_MUL) |=> (!req_valid || gpr_stall)); // R4

endmodule

// File: rtl/mdu_il_div_guard.sv
module mdu_il_div_guard
  import mdu_il_pkg::*;
(
  input  logic       req_valid,
  input  logic [2:0] op,
  input  logic       div_busy,
  output logic       div_stall
);

  assign div_stall = req_valid && unit_class(op) && div_busy;

endmodule

// File: rtl/mdu_issue_interlock.sv
module mdu_issue_interlock
  import mdu_il_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic             in_two_pass,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic [REG_W-1:0] in_dst,
  input  logic             div_busy,
  output logic             stall
);

  logic rst_meta_q, rst_sync_n;
  logic mpy_stall, gpr_stall, div_stall;
  logic issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mdu_il_mpy_track u_mpy (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .issue     (issue),
    .op        (in_op),
    .two_pass  (in_two_pass),
    .req_valid (in_valid),
    .mpy_stall (mpy_stall)
  );

  mdu_il_gpr_track u_gpr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .issue     (issue),
    .req_valid (in_valid),
    .op        (in_op),
    .two_pass  (in_two_pass),
    .src_a     (in_src_a),
    .src_b     (in_src_b),
    .dst       (in_dst),
    .gpr_stall (gpr_stall)
  );

  mdu_il_div_guard u_div (
    .req_valid (in_valid),
    .op        (in_op),
    .div_busy  (div_busy),
    .div_stall (div_stall)
  );

  assign stall = mpy_stall | gpr_stall | div_stall;
  assign issue = in_valid && !stall;

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |-> !stall); // R9

  AST_DIV_HOLDS_UNIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && unit_class(in_op) && div_busy) |-> stall); // R8

  AST_ONE_PASS_FREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(issue && !in_two_pass && (in_op == OP_MULT || in_op == OP_MACC))
     && in_valid && (in_op == OP_MACC || in_op == OP_MFHL) && !div_busy
     && in_src_a == '0 && in_src_b == '0) |-> !stall); // R2

endmodule

// File: tb/mdu_issue_interlock_test.sv
module mdu_issue_interlock_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [2:0] in_op;
  logic       in_two_pass;
  logic [4:0] in_src_a, in_src_b, in_dst;
  logic       div_busy;
  logic       stall;

  int checks = 0;
  int fails  = 0;
  int div_len = 8;
  int div_cnt;

  always #4 clk = ~clk;

  mdu_issue_interlock uut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
    .in_two_pass (in_two_pass), .in_src_a (in_src_a), .in_src_b (in_src_b),
    .in_dst (in_dst), .div_busy (div_busy), .stall (stall)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= 0;
    else if (in_valid && !stall && in_op == 3'd6) div_cnt <= div_len;
    else if (div_cnt > 0) div_cnt <= div_cnt - 1;
  end
  assign div_busy = (div_cnt != 0);

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    in_op = 3'd0; in_two_pass = 1'b0;
    in_src_a = '0; in_src_b = '0; in_dst = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input logic [2:0] op, input logic tp, input logic [4:0] sa,
                     input logic [4:0] sb, input logic [4:0] d, output int stalls);
    stalls = 0;
    in_valid = 1'b1; in_op = op; in_two_pass = tp;
    in_src_a = sa; in_src_b = sb; in_dst = d;
    forever begin
      #1;
      if (!stall) break;
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    int s;
    #1; check("R1 idle after reset", stall, 0);
    check("R9 idle slot", stall, 0);
    for (int op = 0; op < 8; op++) begin
      run(3'(op), 1'b1, 5'd1, 5'd2, 5'd3, s);
      check($sformatf("R1 first op class %0d", op), s, 0);
      idle(6);
    end
  endtask

  task automatic t_one_pass();
    int s;
    run(3'd1, 0, 0, 0, 0, s); run(3'd2, 0, 0, 0, 0, s);
    check("R2 mult1p->macc", s, 0); idle(4);
    run(3'd2, 0, 0, 0, 0, s); run(3'd3, 0, 0, 0, 4, s);
    check("R2 macc1p->mfhl", s, 0); idle(4);
  endtask

  task automatic t_two_pass();
    int s;
    run(3'd1, 1, 0, 0, 0, s); run(3'd2, 0, 0, 0, 0, s);
    check("R3 mult2p->macc", s, 1); idle(4);
    run(3'd2, 1, 0, 0, 0, s); run(3'd3, 0, 0, 0, 4, s);
    check("R3 macc2p->mfhl", s, 1); idle(4);
    run(3'd1, 1, 0, 0, 0, s); run(3'd1, 1, 0, 0, 0, s);
    check("R3 mult2p->mult2p", s, 1); idle(4);
    run(3'd1, 1, 0, 0, 0, s); run(3'd0, 0, 1, 2, 3, s);
    check("R3 mult2p->int", s, 0); idle(4);
  endtask

  task automatic t_mul_hold();
    int s;
    run(3'd5, 0, 1, 2, 5, s); run(3'd0, 0, 1, 2, 6, s);
    check("R4 mul1p->int", s, 1); idle(4);
    run(3'd5, 1, 1, 2, 5, s); run(3'd0, 0, 1, 2, 6, s);
    check("R4 mul2p->int", s, 2); idle(4);
    run(3'd5, 0, 1, 2, 5, s); run(3'd2, 0, 0, 0, 0, s);
    check("R4 mul1p->macc", s, 1); idle(4);
  endtask

  task automatic t_mul_dep();
    int s;
    run(3'd5, 0, 1, 2, 5, s); run(3'd0, 0, 5, 1, 6, s);
    check("R5 mul1p->reader", s, 2); idle(4);
    run(3'd5, 1, 1, 2, 7, s); run(3'd0, 0, 1, 7, 6, s);
    check("R5 mul2p->reader", s, 3); idle(4);
    run(3'd5, 0, 1, 2, 5, s); run(3'd0, 0, 1, 2, 6, s);
    run(3'd0, 0, 5, 5, 8, s);
    check("R5 second follower free", s, 0); idle(4);
    run(3'd5, 0, 1, 2, 0, s); run(3'd0, 0, 0, 0, 6, s);
    check("R10 mul dst r0", s, 1); idle(4);
  endtask

  task automatic t_mf_dep();
    int s;
    run(3'd3, 0, 0, 0, 9, s); run(3'd0, 0, 9, 1, 2, s);
    check("R6 mfhl->reader", s, 1); idle(4);
    run(3'd3, 0, 0, 0, 9, s); run(3'd0, 0, 3, 1, 2, s);
    check("R6 mfhl->independent", s, 0); idle(4);
    run(3'd3, 0, 0, 0, 0, s); run(3'd0, 0, 0, 0, 2, s);
    check("R10 mfhl dst r0", s, 0); idle(4);
  endtask

  task automatic t_mthl();
    int s;
    run(3'd4, 0, 3, 0, 0, s); run(3'd2, 0, 0, 0, 0, s);
    check("R7 mthl->macc", s, 0); idle(4);
  endtask

  task automatic t_divide();
    int s;
    div_len = 8;
    run(3'd6, 0, 1, 2, 0, s);
    run(3'd0, 0, 1, 2, 3, s); check("R8 int during divide", s, 0);
    run(3'd0, 0, 1, 2, 3, s); check("R8 int during divide 2", s, 0);
    run(3'd3, 0, 0, 0, 4, s); check("R8 mfhl waits divide", s, 6);
    idle(4);
    div_len = 5;
    run(3'd6, 0, 1, 2, 0, s); run(3'd6, 0, 1, 2, 0, s);
    check("R8 divide after divide", s, 5);
    idle(8);
  endtask

  initial begin
    rst_n = 1'b0;
    idle(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_one_pass();
    t_two_pass();
    t_mul_hold();
    t_mul_dep();
    t_mf_dep();
    t_mthl();
    t_divide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule